// File: doc/BRIEF.md
# Serial ADC Setup and Readout Sequencer

This block is a host-side controller for a single-channel sigma-delta converter that sits on a serial peripheral bus. After reset it brings the converter up with a fixed sequence. First it sends a command byte that announces a write to the setup register. It then writes the setup value, which selects unity gain, bipolar input, an unbuffered input, a 60 Hz output rate and a self-calibration. From then on it fetches conversion results in an endless loop.

The converter is reached only through its command register. Every register access, read or write, is preceded by one command byte. That byte names the target register in bits 5:4 (00 command, 01 setup, 11 data) and the direction in bit 3 (1 = read). The `pollStatus` input selects how a new result is detected:

- **Pin mode:** the controller watches an active-low data-ready pin.
- **Status mode:** the controller reads the command register back and examines its bit 7.

Each 16-bit result appears on a parallel bus together with a one-cycle valid strobe.

Top module: `adc_seq_top`

## Requirements
- R1: During and after reset, `adcCsN` is 1, `adcSclk` is 1 and `resultValid` is 0. The first two bytes sent after reset are 0x10 and then 0x68.
- R2: Each transfer keeps `adcCsN` low for the whole transfer and raises it between transfers. Command, setup and status transfers take 8 SCLK periods. A data-register read takes 16. SCLK idles high.
- R3: `adcDin` changes only on a falling SCLK edge, and bytes go out MSB first. `adcDout` is captured at the rising SCLK edge.
- R4: With `pollStatus`=0, no data read starts while `drdyN` is high. Once the pin, after a two-flop synchronizer, is seen low, the controller sends 0x38 and clocks in 16 bits.
- R5: With `pollStatus`=1, the controller sends 0x08 and then reads one byte. If bit 7 of that byte is 1, it repeats the 0x08 poll. If bit 7 is 0, it sends 0x38 and reads the 16-bit data register.
- R6: A captured word is presented on `result`, MSB first in bit 15, with `resultValid` high for exactly one cycle. `result` holds that value until the next capture.
- R7: In pin mode, after a read the controller waits for the pin to return high before it accepts the next low. A pin held low yields exactly one read.
- R8: In status mode, `drdyN` has no effect. A pin held low causes no data read while the status bit reports busy.
- R9: During read transfers, `adcDin` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollStatus | input | 1 | 0: detect results by pin, 1: by status byte |
| drdyN | input | 1 | Converter data-ready pin, active low, asynchronous |
| adcDout | input | 1 | Serial data from converter |
| adcSclk | output | 1 | Serial clock, idle high |
| adcCsN | output | 1 | Chip select, active low |
| adcDin | output | 1 | Serial data to converter |
| result | output | DATA_W | Last captured conversion word |
| resultValid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
A result and its strobe appear one system clock after the edge that ends the last SCLK-high half period of the data read, which is the same edge that raises chip select. The bench therefore polls `resultValid` on falling clock edges and compares `result` in that cycle. A pin change takes two synchronizer cycles plus one state step before any command byte can start. Absence checks (no read, pin ignored) are therefore judged after windows of several hundred cycles, far longer than one full poll round. The converter model inside the bench checks byte values, SCLK counts per transfer and protocol order at each chip-select rise, so a fault surfaces in the transfer where it happens.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic       start;   // begin a transfer (datapath idle)
    logic       wide;    // 1: DATA_W bits, 0: 8 bits
    logic [7:0] txByte;  // byte shifted out MSB first
    logic       latch;   // copy shift register to result
  } seqCtl_t;

  localparam logic [7:0] CMD_SETUP_WR = 8'h10;
  localparam logic [7:0] SETUP_VALUE  = 8'h68;
  localparam logic [7:0] CMD_DATA_RD  = 8'h38;
  localparam logic [7:0] CMD_STAT_RD  = 8'h08;

endpackage

// File: rtl/adc_seq_shift.sv
module adc_seq_shift
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              adcDout,
  output logic              adcSclk,
  output logic              adcCsN,
  output logic              adcDin,
  output logic              busy,
  output logic              done,
  output logic              statusBit,
  output logic [DATA_W-1:0] result
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0]  halfCnt;
  logic [BIT_W-1:0]  bitsLeft;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              sclkR;
  logic              csNR;
  logic              dinR;
  logic              busyR;
  logic              doneR;
  logic [DATA_W-1:0] resultR;
  logic              tick;

  assign tick = (halfCnt == HALF_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt  <= '0;
      bitsLeft <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      sclkR    <= 1'b1;
      csNR     <= 1'b1;
      dinR     <= 1'b0;
      busyR    <= 1'b0;
      doneR    <= 1'b0;
      resultR  <= '0;
    end else begin
      doneR <= 1'b0;
      if (ctl.latch) resultR <= rxShift;
      if (!busyR) begin
        halfCnt <= '0;
        if (ctl.start) begin
          busyR    <= 1'b1;
          csNR     <= 1'b0;
          txShift  <= {ctl.txByte, {(DATA_W-8){1'b0}}};
          bitsLeft <= ctl.wide ? BIT_W'(DATA_W) : BIT_W'(8);
        end
      end else if (!tick) begin
        halfCnt <= halfCnt + 1'b1;
      end else begin
        halfCnt <= '0;
        if (!sclkR) begin
          // rising edge: capture input, advance output
          sclkR    <= 1'b1;
          rxShift  <= {rxShift[DATA_W-2:0], adcDout};
          txShift  <= {txShift[DATA_W-2:0], 1'b0};
          bitsLeft <= bitsLeft - 1'b1;
        end else if (bitsLeft == '0) begin
          busyR <= 1'b0;
          csNR  <= 1'b1;
          doneR <= 1'b1;
        end else begin
          // falling edge: present next bit
          sclkR <= 1'b0;
          dinR  <= txShift[DATA_W-1];
        end
      end
    end
  end

  assign adcSclk   = sclkR;
  assign adcCsN    = csNR;
  assign adcDin    = dinR;
  assign busy      = busyR;
  assign done      = doneR;
  assign statusBit = rxShift[7];
  assign result    = resultR;

  // R2: clock idles high whenever the device is deselected
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    csNR |-> sclkR);

  // R2: chip select only rises when a transfer completes
  a_r2_cs_rise_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csNR) |-> doneR);

  // R3: serial output moves only with a falling clock
  a_r3_din_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dinR) |-> $fell(sclkR));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pollStatus,
  input  logic    drdyN,
  input  logic    busy,
  input  logic    done,
  input  logic    statusBit,
  output seqCtl_t ctl,
  output logic    resultValid
);

  typedef enum logic [2:0] {
    S_CMD_SETUP, S_WR_SETUP, S_REARM, S_POLL,
    S_CMD_STAT, S_RD_STAT, S_CMD_DATA, S_RD_DATA
  } seqState_t;

  seqState_t state;
  logic      pending;
  logic      drdyMeta;
  logic      drdySync;
  logic      validR;
  logic      isXfer;

  always_comb begin
    ctl    = '0;
    isXfer = 1'b1;
    unique case (state)
      S_CMD_SETUP: ctl.txByte = CMD_SETUP_WR;
      S_WR_SETUP:  ctl.txByte = SETUP_VALUE;
      S_CMD_STAT:  ctl.txByte = CMD_STAT_RD;
      S_RD_STAT:   ctl.txByte = 8'h00;
      S_CMD_DATA:  ctl.txByte = CMD_DATA_RD;
      S_RD_DATA:   ctl.wide   = 1'b1;
      default:     isXfer     = 1'b0;
    endcase
    ctl.start = isXfer && !pending;
    ctl.latch = (state == S_RD_DATA) && pending && done;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_CMD_SETUP;
      pending  <= 1'b0;
      drdyMeta <= 1'b1;
      drdySync <= 1'b1;
      validR   <= 1'b0;
    end else begin
      drdyMeta <= drdyN;
      drdySync <= drdyMeta;
      validR   <= 1'b0;
      if (ctl.start) pending <= 1'b1;
      if (pending && done) begin
        pending <= 1'b0;
        unique case (state)
          S_CMD_SETUP: state <= S_WR_SETUP;
          S_WR_SETUP:  state <= S_POLL;
          S_CMD_STAT:  state <= S_RD_STAT;
          S_RD_STAT:   state <= statusBit ? S_CMD_STAT : S_CMD_DATA;
          S_CMD_DATA:  state <= S_RD_DATA;
          S_RD_DATA: begin
            state  <= S_REARM;
            validR <= 1'b1;
          end
          default:     state <= state;
        endcase
      end else if (state == S_REARM) begin
        if (pollStatus || drdySync) state <= S_POLL;
      end else if (state == S_POLL) begin
        if (pollStatus)     state <= S_CMD_STAT;
        else if (!drdySync) state <= S_CMD_DATA;
      end
    end
  end

  assign resultValid = validR;

  // R6: valid strobe lasts one cycle
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R2: a new transfer is only requested from an idle datapath
  a_r2_start_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |-> !busy);

  // R6: the strobe follows a completed transfer
  a_r6_valid_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> $past(done));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollStatus,
  input  logic              drdyN,
  input  logic              adcDout,
  output logic              adcSclk,
  output logic              adcCsN,
  output logic              adcDin,
  output logic [DATA_W-1:0] result,
  output logic              resultValid
);

  seqCtl_t ctl;
  logic    busy;
  logic    done;
  logic    statusBit;

  adc_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pollStatus  (pollStatus),
    .drdyN       (drdyN),
    .busy        (busy),
    .done        (done),
    .statusBit   (statusBit),
    .ctl         (ctl),
    .resultValid (resultValid)
  );

  adc_seq_shift #(.HALF_DIV(HALF_DIV), .DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .adcDout   (adcDout),
    .adcSclk   (adcSclk),
    .adcCsN    (adcCsN),
    .adcDin    (adcDin),
    .busy      (busy),
    .done      (done),
    .statusBit (statusBit),
    .result    (result)
  );

endmodule

// File: tb/adc_seq_top_bench.sv
module adc_seq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pollStatus = 1'b0;
  logic        drdyN;
  logic        adcDout;
  logic        adcSclk, adcCsN, adcDin;
  logic [15:0] result;
  logic        resultValid;

  int checks = 0;
  int errors = 0;

  // converter model state
  int          kind = 0;          // 0 cmd, 1 setup wr, 2 data rd, 3 status rd
  logic [15:0] outWord = '0;
  logic [7:0]  inByte = '0;
  int          edges = 0;
  logic        open = 1'b0;
  logic [7:0]  firstBytes [0:1];
  int          logN = 0;
  logic [7:0]  lastCmd = '0;
  int          dataReads = 0;
  int          statReads = 0;
  int          protoErr = 0;
  int          edgeErr = 0;
  int          dinErr = 0;
  logic        expectPoll = 1'b0;
  logic        lastReady = 1'b0;

  // stimulus-owned controls
  logic [15:0] dataVal = '0;
  int          armCnt = 0;
  int          statTarget = 0;
  logic        pinLow = 1'b0;

  logic statBusy;
  assign statBusy = !((armCnt > dataReads) && (statReads >= statTarget));
  assign drdyN    = !(pinLow || (armCnt > dataReads));
  assign adcDout  = outWord[15];

  adc_seq_top u_adc_seq_top (
    .clk(clk), .rstN(rstN), .pollStatus(pollStatus), .drdyN(drdyN),
    .adcDout(adcDout), .adcSclk(adcSclk), .adcCsN(adcCsN), .adcDin(adcDin),
    .result(result), .resultValid(resultValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge adcCsN) if (rstN) begin
    open   = 1'b1;
    inByte = '0;
    edges  = 0;
    if (kind == 2)      outWord = dataVal;
    else if (kind == 3) outWord = {statBusy, 7'h2A, 8'h00};
    else                outWord = '0;
  end

  always @(posedge adcSclk) if (open && !adcCsN) begin
    inByte  = {inByte[6:0], adcDin};
    edges   = edges + 1;
    outWord = {outWord[14:0], 1'b0};
    if ((kind == 2 || kind == 3) && adcDin) dinErr = dinErr + 1;  // R9
  end

  always @(posedge adcCsN) if (open) begin
    open = 1'b0;
    if (edges != ((kind == 2) ? 16 : 8)) edgeErr = edgeErr + 1;    // R2
    case (kind)
      0: begin
        if (logN < 2) firstBytes[logN] = inByte;
        logN    = logN + 1;
        lastCmd = inByte;
        if (expectPoll && inByte != 8'h08) protoErr = protoErr + 1;  // R5
        expectPoll = 1'b0;
        if (inByte == 8'h38 && pollStatus && !lastReady) protoErr = protoErr + 1;
        if (inByte[5:4] == 2'b01 && !inByte[3])      kind = 1;
        else if (inByte[5:4] == 2'b11 && inByte[3])  kind = 2;
        else if (inByte[5:4] == 2'b00 && inByte[3])  kind = 3;
        else begin protoErr = protoErr + 1; kind = 0; end
      end
      1: begin
        if (logN < 2) firstBytes[logN] = inByte;
        logN = logN + 1;
        kind = 0;
      end
      2: begin
        dataReads = dataReads + 1;
        lastReady = 1'b0;
        kind = 0;
      end
      default: begin
        lastReady  = !statBusy;
        expectPoll = statBusy;
        statReads  = statReads + 1;
        kind = 0;
      end
    endcase
  end

  // output monitor: strobe width, hold, DIN stability
  int          validCnt = 0;
  int          validLong = 0;
  int          holdErr = 0;
  int          dinChg = 0;
  logic        prevValid = 1'b0;
  logic        prevSclk = 1'b1;
  logic        prevDin = 1'b0;
  logic [15:0] heldVal = '0;
  always @(negedge clk) if (rstN) begin
    if (resultValid) begin
      validCnt = validCnt + 1;
      if (prevValid) validLong = validLong + 1;
      heldVal = result;
    end else if (validCnt > 0 && result != heldVal) holdErr = holdErr + 1;
    if (!adcCsN && adcSclk && prevSclk && adcDin != prevDin) dinChg = dinChg + 1;
    prevValid = resultValid;
    prevSclk  = adcSclk;
    prevDin   = adcDin;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitValid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (resultValid) seen = 1'b1;
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors = errors + 1;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  initial begin
    bit seen;
    int d0;
    int s0;
    logic [15:0] v;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(adcCsN == 1'b1, "R1 csN in reset", adcCsN, 1);
    check(adcSclk == 1'b1, "R1 sclk in reset", adcSclk, 1);
    check(resultValid == 1'b0, "R1 valid in reset", resultValid, 0);
    rstN = 1'b1;

    // R1/R4: setup bytes then idle while pin is high
    repeat (300) @(negedge clk);
    check(logN == 2, "R4 no read while pin high", logN, 2);
    check(firstBytes[0] == 8'h10, "R1 first byte", firstBytes[0], 8'h10);
    check(firstBytes[1] == 8'h68, "R1 setup byte", firstBytes[1], 8'h68);
    check(validCnt == 0, "R4 no result while pin high", validCnt, 0);

    // R4/R6: pin-mode sweep (walking ones plus corner words)
    for (int i = 0; i < 20; i++) begin
      if (i < 16)       v = 16'h1 << i;
      else if (i == 16) v = 16'h0000;
      else if (i == 17) v = 16'hFFFF;
      else              v = 16'hA5C3 ^ (16'(i) * 16'h1111);
      dataVal = v;
      d0 = dataReads;
      armCnt = armCnt + 1;
      waitValid(seen);
      check(seen, "R4 pin-mode result strobe", seen, 1);
      check(result == v, "R6 pin-mode result", result, v);
      check(lastCmd == 8'h38, "R4 data read command", lastCmd, 8'h38);
      @(negedge clk);
      check(!resultValid, "R6 single-cycle strobe", resultValid, 0);
      repeat (100) @(negedge clk);
      check(dataReads == d0 + 1, "R7 one read per ready", dataReads, d0 + 1);
      check(result == v, "R6 result holds", result, v);
    end

    // R7: pin held low gives exactly one read
    d0 = dataReads;
    pinLow = 1'b1;
    repeat (800) @(negedge clk);
    check(dataReads == d0 + 1, "R7 pin held low", dataReads, d0 + 1);

    // R5/R8: status mode, pin low is ignored
    pollStatus = 1'b1;
    for (int k = 0; k < 5; k++) begin
      d0 = dataReads;
      repeat (400) @(negedge clk);
      check(dataReads == d0, "R8 pin ignored while busy", dataReads, d0);
      check(lastCmd == 8'h08, "R5 status poll command", lastCmd, 8'h08);
      v = 16'h1357 * 16'(k + 3) ^ 16'h8001;
      dataVal = v;
      s0 = statReads;
      statTarget = statReads + k;
      armCnt = dataReads + 1;
      waitValid(seen);
      check(seen, "R5 status-mode result strobe", seen, 1);
      check(result == v, "R5 status-mode result", result, v);
      check(statReads - s0 >= k + 1, "R5 busy polls repeated", statReads - s0, k + 1);
    end

    check(protoErr == 0, "R5 command order", protoErr, 0);
    check(edgeErr == 0, "R2 clocks per transfer", edgeErr, 0);
    check(dinErr == 0, "R9 din low on reads", dinErr, 0);
    check(dinChg == 0, "R3 din changes on fall", dinChg, 0);
    check(validLong == 0, "R6 strobe width", validLong, 0);
    check(holdErr == 0, "R6 result stable", holdErr, 0);
    finishRun();
  end

endmodule